// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside the sequencer of a small 8-bit CPU and decides when the CPU should break off into a service routine, and which routine it should enter. It has five request sources. Each source has a fixed index, and that index sets both its polling rank and its vector: 0 is external line 0, 1 is timer 0 overflow, 2 is external line 1, 3 is timer 1 overflow and 4 is the serial port. The two external lines are active low. Each one can be set to latch a falling edge or to follow the low level. The timer inputs are one-cycle overflow pulses, and the controller latches each pulse in a flag. The serial request is a level that the serial logic holds and clears itself.

The CPU loads an enable register and a priority register through two plain write strobes. It raises `boundary_i` for one cycle at each instruction end, and `reti_i` for one cycle when a service routine returns. When the controller accepts a request, it pulses `take_o` and holds the vector address on `vec_o`. The CPU pushes its own return address, which is outside this block. `lvl_o` shows which priority levels are currently in service. Every pin is a plain control or status signal. No port carries a data stream, so no port has a valid/ready handshake.

Top module: `vic_irq_ctrl`

## Requirements
- R1: Source i is eligible only when enable bit i (bits 4:0 of `ie_wdata_i` as last written) and the global enable bit 5 are both set. A pending source with either bit clear is never taken.
- R2: Priority bit i (bits 4:0 of `ip_wdata_i`) set puts source i at high level. An eligible high-level source wins over every low-level source, whatever their indices.
- R3: Within one level, the eligible source with the lowest index wins.
- R4: A request is accepted only in a cycle where `boundary_i` is high. `take_o` is high for exactly the cycle after that boundary cycle, and is low at all other times.
- R5: On acceptance, `vec_o` becomes 0x0003 + 8 × index. The five vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R6: Acceptance sets the in-service bit for the source's level: `lvl_o[1]` for high level, `lvl_o[0]` for low level.
- R7: While `lvl_o[1]` is set, nothing is accepted. While only `lvl_o[0]` is set, only a high-level source is accepted.
- R8: `reti_i` clears `lvl_o[1]` if it is set, and otherwise clears `lvl_o[0]`. A boundary in the same cycle is judged against the levels as they stood before that return.
- R9: When `ext_edge_i[g]` is 1, a high-to-low transition on `ext_n_i[g]` latches a request. The latch clears when that source is taken, unless a new transition arrives in the same cycle, in which case the request stays latched. When `ext_edge_i[g]` is 0, the request is present while the pin is low and is never cleared by acceptance.
- R10: A pulse on `tmr_ovf_i[g]` latches a request that clears when that source is taken. `ser_req_i` is a level that acceptance never clears.
- R11: After reset, `take_o` and `lvl_o` are 0 and both registers are 0. A boundary with no eligible source produces no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n_i | input | 2 | External request lines, active low |
| ext_edge_i | input | 2 | Trigger select per external line: 1 edge, 0 level |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_req_i | input | 1 | Serial port request level |
| ie_we_i | input | 1 | Enable register write strobe |
| ie_wdata_i | input | 6 | Enable data: bit 5 global, bits 4:0 per source |
| ip_we_i | input | 1 | Priority register write strobe |
| ip_wdata_i | input | 5 | Priority data: bit i set = source i high |
| boundary_i | input | 1 | Instruction-end strobe from the CPU |
| reti_i | input | 1 | Return-from-service strobe |
| take_o | output | 1 | Take-interrupt pulse |
| vec_o | output | 16 | Vector address of the last accepted source |
| lvl_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
Two pairs of events can land in the same cycle. The first pair is a return strobe and an instruction boundary. The bench raises both at once while both levels are in service and a high request is waiting. It expects no take, and expects only the high level to drop. Random iterations also pair the two freely and compare against a model that judges acceptance on the levels before the return. The second pair is a fresh falling edge on an edge-mode line arriving in the cycle that line's latch is cleared by acceptance. The bench times the pin fall one cycle before the boundary, then looks for a second take of the same vector after a return, which shows that the new edge was kept.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
  localparam int unsigned LVL_N  = 2;

  function automatic int unsigned vec_at(input int unsigned base, input int unsigned step,
                                         input int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/vic_ext_detect.sv
module vic_ext_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic smp_q;
  logic prv_q;
  logic flag_q;
  logic fall;

  assign fall = prv_q & ~smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      prv_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      smp_q <= pin_n_i;
      prv_q <= smp_q;
      if (edge_mode_i) flag_q <= fall | (flag_q & ~clr_i);
      else             flag_q <= 1'b0;
    end
  end

  assign req_o = edge_mode_i ? flag_q : ~smp_q;

  AST_FLAG_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(prv_q && !smp_q)); // R9
endmodule

// File: rtl/vic_pulse_flag.sv
module vic_pulse_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned SRC_N = 5,
  parameter int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0] req_i,
  input  logic [SRC_N-1:0] prio_i,
  input  logic [1:0]       act_i,
  output logic             valid_o,
  output logic             hi_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [SRC_N-1:0] hi_req;
  logic [SRC_N-1:0] lo_req;
  logic [SRC_N-1:0] sel;

  assign hi_req = req_i & prio_i;
  assign lo_req = req_i & ~prio_i;

  always_comb begin
    sel  = '0;
    hi_o = 1'b0;
    if (!act_i[1] && (|hi_req)) begin
      sel  = hi_req;
      hi_o = 1'b1;
    end else if ((act_i == 2'b00) && (|lo_req)) begin
      sel = lo_req;
    end
    valid_o = |sel;
    idx_o   = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (sel[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
  parameter int unsigned EXT_N    = 2,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXT_N-1:0]       ext_n_i,
  input  logic [EXT_N-1:0]       ext_edge_i,
  input  logic [EXT_N-1:0]       tmr_ovf_i,
  input  logic                   ser_req_i,
  input  logic                   ie_we_i,
  input  logic [2*EXT_N+1:0]     ie_wdata_i,
  input  logic                   ip_we_i,
  input  logic [2*EXT_N:0]       ip_wdata_i,
  input  logic                   boundary_i,
  input  logic                   reti_i,
  output logic                   take_o,
  output logic [ADDR_W-1:0]      vec_o,
  output logic [1:0]             lvl_o
);
  import vic_pkg::*;

  localparam int unsigned SRC_N   = 2 * EXT_N + 1;
  localparam int unsigned IDX_W   = $clog2(SRC_N);
  localparam int unsigned GIE_BIT = SRC_N;
  localparam int unsigned VEC_TOP = VEC_BASE + VEC_STEP * (SRC_N - 1);

  logic [SRC_N-1:0]  en_q;
  logic              gie_q;
  logic [SRC_N-1:0]  prio_q;
  logic [SRC_N-1:0]  pend;
  logic [SRC_N-1:0]  req_q;
  logic [SRC_N-1:0]  clr_v;
  logic              pick_valid;
  logic              pick_hi;
  logic [IDX_W-1:0]  pick_idx;
  logic              accept;
  logic              take_q;
  logic [ADDR_W-1:0] vec_q;
  logic [LVL_N-1:0]  lvl_q;
  logic [LVL_N-1:0]  lvl_n;

  // Register file written by the CPU
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      if (ie_we_i) begin
        en_q  <= ie_wdata_i[SRC_N-1:0];
        gie_q <= ie_wdata_i[GIE_BIT];
      end
      if (ip_we_i) prio_q <= ip_wdata_i;
    end
  end

  // Source capture: external line and timer flag pairs, serial last
  for (genvar g = 0; g < EXT_N; g++) begin : g_src
    vic_ext_detect u_ext (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_n_i     (ext_n_i[g]),
      .edge_mode_i (ext_edge_i[g]),
      .clr_i       (clr_v[2*g]),
      .req_o       (pend[2*g])
    );
    vic_pulse_flag u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tmr_ovf_i[g]),
      .clr_i  (clr_v[2*g+1]),
      .flag_o (pend[2*g+1])
    );
  end
  assign pend[SRC_N-1] = ser_req_i;

  // Masked requests registered ahead of resolution
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= pend & en_q & {SRC_N{gie_q}};
  end

  vic_arbiter #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_arb (
    .req_i   (req_q),
    .prio_i  (prio_q),
    .act_i   (lvl_q),
    .valid_o (pick_valid),
    .hi_o    (pick_hi),
    .idx_o   (pick_idx)
  );

  assign accept = boundary_i & pick_valid;
  assign clr_v  = accept ? (SRC_N'(1) << pick_idx) : '0;

  always_comb begin
    lvl_n = lvl_q;
    if (reti_i) begin
      if (lvl_q[LVL_HI]) lvl_n[LVL_HI] = 1'b0;
      else               lvl_n[LVL_LO] = 1'b0;
    end
    if (accept) begin
      if (pick_hi) lvl_n[LVL_HI] = 1'b1;
      else         lvl_n[LVL_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      lvl_q  <= '0;
    end else begin
      take_q <= accept;
      lvl_q  <= lvl_n;
      if (accept) vec_q <= ADDR_W'(vec_at(VEC_BASE, VEC_STEP, 32'(pick_idx)));
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign lvl_o  = lvl_q;

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(boundary_i)); // R4
  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q[LVL_HI] && boundary_i) |=> !take_q); // R7
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (vec_q >= ADDR_W'(VEC_BASE) && vec_q <= ADDR_W'(VEC_TOP))); // R5
  AST_TAKE_MARKS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (lvl_q != '0)); // R6
  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !boundary_i && lvl_q != '0) |=>
      ($countones(lvl_q) == $countones($past(lvl_q)) - 1)); // R8
endmodule

// File: tb/vic_irq_ctrl_tb.sv
module vic_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ext_n_i;
  logic [1:0]  ext_edge_i;
  logic [1:0]  tmr_ovf_i;
  logic        ser_req_i;
  logic        ie_we_i;
  logic [5:0]  ie_wdata_i;
  logic        ip_we_i;
  logic [4:0]  ip_wdata_i;
  logic        boundary_i;
  logic        reti_i;
  logic        take_o;
  logic [15:0] vec_o;
  logic [1:0]  lvl_o;

  always #4 clk = ~clk;

  vic_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n_i), .ext_edge_i(ext_edge_i),
    .tmr_ovf_i(tmr_ovf_i), .ser_req_i(ser_req_i), .ie_we_i(ie_we_i),
    .ie_wdata_i(ie_wdata_i), .ip_we_i(ip_we_i), .ip_wdata_i(ip_wdata_i),
    .boundary_i(boundary_i), .reti_i(reti_i), .take_o(take_o),
    .vec_o(vec_o), .lvl_o(lvl_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  bit [1:0] m_edge, m_ext, m_eflag, m_tflag;
  bit       m_ser;
  bit [5:0] m_ie;
  bit [4:0] m_ip;
  bit [1:0] m_lvl;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit [4:0] m_pend();
    bit [4:0] p;
    p[0] = m_edge[0] ? m_eflag[0] : ~m_ext[0];
    p[1] = m_tflag[0];
    p[2] = m_edge[1] ? m_eflag[1] : ~m_ext[1];
    p[3] = m_tflag[1];
    p[4] = m_ser;
    return p;
  endfunction

  function automatic int m_pick();
    bit [4:0] el, hi, lo;
    el = m_pend() & m_ie[4:0] & {5{m_ie[5]}};
    hi = el & m_ip;
    lo = el & ~m_ip;
    if (!m_lvl[1] && hi != 0) begin
      for (int i = 0; i < 5; i++) if (hi[i]) return i;
    end
    if (m_lvl == 2'b00 && lo != 0) begin
      for (int i = 0; i < 5; i++) if (lo[i]) return i;
    end
    return -1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ie(input bit [5:0] v);
    ie_we_i = 1'b1; ie_wdata_i = v; tick(1); ie_we_i = 1'b0; m_ie = v;
  endtask

  task automatic wr_ip(input bit [4:0] v);
    ip_we_i = 1'b1; ip_wdata_i = v; tick(1); ip_we_i = 1'b0; m_ip = v;
  endtask

  task automatic set_ext(input int g, input bit v, input bit mode);
    if (mode && m_ext[g] && !v) m_eflag[g] = 1'b1;
    if (!mode) m_eflag[g] = 1'b0;
    m_edge[g] = mode; m_ext[g] = v;
    ext_edge_i[g] = mode; ext_n_i[g] = v;
  endtask

  task automatic pulse_tmr(input int g);
    tmr_ovf_i[g] = 1'b1; tick(1); tmr_ovf_i[g] = 1'b0; m_tflag[g] = 1'b1;
  endtask

  task automatic m_apply(input int e, input bit rt, input bit coincide);
    if (rt) begin
      if (m_lvl[1]) m_lvl[1] = 1'b0; else m_lvl[0] = 1'b0;
    end
    if (e >= 0) begin
      m_lvl[m_ip[e] ? 1 : 0] = 1'b1;
      case (e)
        0: m_eflag[0] = 1'b0;
        1: m_tflag[0] = 1'b0;
        2: m_eflag[1] = 1'b0;
        3: m_tflag[1] = 1'b0;
        default: ;
      endcase
    end
    if (coincide) m_eflag[0] = 1'b1;
  endtask

  // Pulse the boundary (optionally with return, optionally with a fresh ext0 fall)
  task automatic bnd(input string rq, input bit rt, input bit coincide);
    int e;
    tick(4);
    e = m_pick();
    if (coincide) begin
      ext_n_i[0] = 1'b0; m_ext[0] = 1'b0; tick(1);
    end
    boundary_i = 1'b1; reti_i = rt; tick(1);
    boundary_i = 1'b0; reti_i = 1'b0;
    m_apply(e, rt, coincide);
    chk(rq, "take", int'(take_o), (e >= 0) ? 1 : 0);
    if (e >= 0) chk(rq, "vec", int'(vec_o), 3 + 8 * e);
    chk(rq, "lvl", int'(lvl_o), int'(m_lvl));
  endtask

  task automatic do_reti(input string rq);
    reti_i = 1'b1; tick(1); reti_i = 1'b0;
    m_apply(-1, 1'b1, 1'b0);
    chk(rq, "lvl", int'(lvl_o), int'(m_lvl));
    chk(rq, "take", int'(take_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst_n = 1'b0; ext_n_i = 2'b11; ext_edge_i = 2'b00; tmr_ovf_i = 2'b00;
    ser_req_i = 1'b0; ie_we_i = 1'b0; ie_wdata_i = '0; ip_we_i = 1'b0; ip_wdata_i = '0;
    boundary_i = 1'b0; reti_i = 1'b0;
    m_edge = 0; m_ext = 2'b11; m_eflag = 0; m_tflag = 0; m_ser = 0; m_ie = 0; m_ip = 0; m_lvl = 0;
    tick(3); rst_n = 1'b1; tick(1);

    // R11 reset state and empty boundary
    chk("R11", "take", int'(take_o), 0);
    chk("R11", "lvl", int'(lvl_o), 0);
    bnd("R11", 1'b0, 1'b0);

    // R1 global enable gate
    set_ext(0, 1'b0, 1'b0);
    wr_ie(6'b000001);
    bnd("R1", 1'b0, 1'b0);
    chk("R1", "no take without global", int'(take_o), 0);
    wr_ie(6'b100001);
    bnd("R1", 1'b0, 1'b0);
    chk("R5", "vec ext0", int'(vec_o), 16'h0003);
    chk("R6", "low level set", int'(lvl_o), 2'b01);

    // R7 same level blocked, high preempts low
    set_ext(1, 1'b0, 1'b0);
    wr_ie(6'b100101);
    bnd("R7", 1'b0, 1'b0);
    m_ser = 1'b1; ser_req_i = 1'b1;
    wr_ip(5'b10000);
    wr_ie(6'b110101);
    bnd("R2", 1'b0, 1'b0);
    chk("R2", "serial high vec", int'(vec_o), 16'h0023);
    bnd("R7", 1'b0, 1'b0);

    // R8 return and boundary together
    bnd("R8", 1'b1, 1'b0);
    chk("R8", "only high dropped", int'(lvl_o), 2'b01);
    bnd("R10", 1'b0, 1'b0);
    chk("R10", "serial still pending", int'(take_o), 1);
    bnd("R8", 1'b1, 1'b0);
    do_reti("R8");
    m_ser = 1'b0; ser_req_i = 1'b0;
    bnd("R9", 1'b0, 1'b0);
    chk("R9", "level source retaken", int'(vec_o), 16'h0003);
    do_reti("R8");

    // R3 ordering inside low level, R10 timer flags
    wr_ip(5'b00000);
    wr_ie(6'b111111);
    set_ext(0, 1'b1, 1'b0);
    pulse_tmr(0); pulse_tmr(1);
    bnd("R3", 1'b0, 1'b0);
    chk("R3", "timer0 first", int'(vec_o), 16'h000B);
    do_reti("R3");
    bnd("R3", 1'b0, 1'b0);
    set_ext(1, 1'b1, 1'b0);
    do_reti("R3");
    bnd("R10", 1'b0, 1'b0);
    chk("R10", "timer1 vec", int'(vec_o), 16'h001B);
    do_reti("R10");
    bnd("R10", 1'b0, 1'b0);
    chk("R10", "timer flag cleared", int'(take_o), 0);

    // R4 no take without boundary
    set_ext(0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk("R4", "no boundary no take", int'(take_o), 0);
    end
    bnd("R4", 1'b0, 1'b0);
    do_reti("R4");

    // R9 edge latch, clear on take, coincident edge kept
    set_ext(0, 1'b1, 1'b1); tick(4);
    set_ext(0, 1'b0, 1'b1); tick(4);
    set_ext(0, 1'b1, 1'b1);
    bnd("R9", 1'b0, 1'b0);
    chk("R9", "edge latched after pin release", int'(vec_o), 16'h0003);
    do_reti("R9");
    bnd("R9", 1'b0, 1'b0);
    set_ext(0, 1'b0, 1'b1); tick(4);
    set_ext(0, 1'b1, 1'b1);
    bnd("R9", 1'b0, 1'b1);
    ext_n_i[0] = 1'b1; m_ext[0] = 1'b1;
    do_reti("R9");
    bnd("R9", 1'b0, 1'b0);
    chk("R9", "coincident edge kept", int'(take_o), 1);
    do_reti("R9");

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      bit co;
      if ($urandom_range(0, 3) == 0) wr_ip(5'($urandom));
      if ($urandom_range(0, 3) == 0) wr_ie({($urandom_range(0, 4) != 0), 5'($urandom)});
      for (int g = 0; g < 2; g++) set_ext(g, 1'($urandom), 1'($urandom));
      tick(1);
      for (int g = 0; g < 2; g++) if ($urandom_range(0, 2) == 0) pulse_tmr(g);
      m_ser = 1'($urandom_range(0, 2) == 0); ser_req_i = m_ser;
      co = m_edge[0] && m_ext[0] && ($urandom_range(0, 3) == 0);
      bnd("R3", 1'($urandom), co);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule